// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches a bank of asynchronous external event lines and turns selected transitions into interrupts. Every line is resynchronised to the block clock, and its edges are found by comparing the synchronised level with its value one cycle earlier. Each line has its own rising-edge enable and its own falling-edge enable. Either one, or both, may be set. A detected edge that is enabled latches the line's pending bit. If the line's interrupt-mask bit is set, the same edge also drives a single-cycle pulse on that line's interrupt output.

Software reaches the block through a simple word-addressed register port. The write strobe acts in the cycle it is sampled, and read data is combinational on the offset. Through this port software programs the mask and edge-select registers, can raise any line by a software-event write, and acknowledges pending lines by writing ones to the pending register. An event-mask register is kept for an event path that lies outside this block. It can be written and read back, but it has no effect inside the block.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, all six registers read zero and no interrupt output is high.
- R2: The interrupt mask (0x00), event mask (0x04), rising select (0x08), falling select (0x0C) and software-event (0x10) registers read back the last value written to them. Only bits 0 to NUM_LINES-1 are stored, and bits at or above NUM_LINES always read zero.
- R3: A 0-to-1 change on a line whose rising-select bit is 1 sets that line's pending bit. The pending bit reads 1 after the third rising clock edge following the change (two synchroniser flops, then the edge register).
- R4: A 1-to-0 change on a line whose falling-select bit is 1 sets that line's pending bit, with the same latency as R3.
- R5: A change on a line whose select bit for that direction is 0 sets no pending bit and produces no pulse.
- R6: A write to the pending register (0x14) clears each bit written as 1 and leaves each bit written as 0 unchanged. Such a write never sets a pending bit.
- R7: If a pending bit is being set by an event in the same cycle that a pending write clears it, the bit stays 1.
- R8: When an event sets a pending bit, that line's output is high for exactly the following cycle if its interrupt-mask bit is 1. If the mask bit is 0, no pulse appears, but the pending bit is still set.
- R9: Writing 1 to a bit of the software-event register sets the matching pending bit on that clock edge and pulses the line if it is unmasked. Bits written as 0 have no effect.
- R10: Reads of any offset other than the six listed return zero. Writes to them change no register and produce no pulse.
- R11: The event-mask register does not affect pending bits or interrupt pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | NUM_LINES | Asynchronous external event lines |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset of the register access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` (combinational) |
| irq_pulse | output | NUM_LINES | Per-line one-cycle interrupt pulses |

## Verification
The bench builds the block with its defaults: 23 lines, 32-bit data, an 8-bit offset and two synchroniser stages. Because there are fewer lines than data bits, the always-zero upper bits of every register can be observed. Because 23 is not a power of two, any decode that spills into bit 23 or above would show up. With two synchroniser stages, the set-over-clear collision can be placed on an exact cycle, three edges after a line changes. Random masks and select patterns, applied across the full 23-bit bank, drive rising, falling, both-edge and unselected transitions on many lines at once.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int unsigned OFS_IMASK = 32'h00;
  localparam int unsigned OFS_EMASK = 32'h04;
  localparam int unsigned OFS_RSEL  = 32'h08;
  localparam int unsigned OFS_FSEL  = 32'h0C;
  localparam int unsigned OFS_SWEV  = 32'h10;
  localparam int unsigned OFS_PEND  = 32'h14;

  typedef enum logic [2:0] {
    SEL_IMASK, SEL_EMASK, SEL_RSEL, SEL_FSEL, SEL_SWEV, SEL_PEND, SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int unsigned NUM_LINES   = 23,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_i,
  output logic [NUM_LINES-1:0] rise_o,
  output logic [NUM_LINES-1:0] fall_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [NUM_LINES-1:0] stage_q [SYNC_STAGES];
  logic [NUM_LINES-1:0] prev_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= line_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stage_q[LAST];
  end

  always_comb begin
    rise_o = stage_q[LAST] & ~prev_q;
    fall_o = ~stage_q[LAST] & prev_q;
  end
endmodule

// File: rtl/extint_regs.sv
module extint_regs
  import extint_pkg::*;
#(
  parameter int unsigned NUM_LINES = 23,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_LINES-1:0] pend_i,
  output logic [DATA_W-1:0]    rdata,
  output logic [NUM_LINES-1:0] imask_o,
  output logic [NUM_LINES-1:0] emask_o,
  output logic [NUM_LINES-1:0] rsel_o,
  output logic [NUM_LINES-1:0] fsel_o,
  output logic [NUM_LINES-1:0] swev_o,
  output logic [NUM_LINES-1:0] sw_set_o,
  output logic [NUM_LINES-1:0] clr_o
);
  reg_sel_e             sel;
  logic [NUM_LINES-1:0] wbits;
  logic                 imask_en, emask_en, rsel_en, fsel_en, swev_en;

  always_comb begin
    if      (addr == ADDR_W'(OFS_IMASK)) sel = SEL_IMASK;
    else if (addr == ADDR_W'(OFS_EMASK)) sel = SEL_EMASK;
    else if (addr == ADDR_W'(OFS_RSEL))  sel = SEL_RSEL;
    else if (addr == ADDR_W'(OFS_FSEL))  sel = SEL_FSEL;
    else if (addr == ADDR_W'(OFS_SWEV))  sel = SEL_SWEV;
    else if (addr == ADDR_W'(OFS_PEND))  sel = SEL_PEND;
    else                                 sel = SEL_NONE;
  end

  always_comb begin
    wbits    = wdata[NUM_LINES-1:0];
    imask_en = wr_en && (sel == SEL_IMASK);
    emask_en = wr_en && (sel == SEL_EMASK);
    rsel_en  = wr_en && (sel == SEL_RSEL);
    fsel_en  = wr_en && (sel == SEL_FSEL);
    swev_en  = wr_en && (sel == SEL_SWEV);
    sw_set_o = swev_en ? wbits : '0;
    clr_o    = (wr_en && (sel == SEL_PEND)) ? wbits : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imask_o <= '0;
      emask_o <= '0;
      rsel_o  <= '0;
      fsel_o  <= '0;
      swev_o  <= '0;
    end else begin
      if (imask_en) imask_o <= wbits;
      if (emask_en) emask_o <= wbits;
      if (rsel_en)  rsel_o  <= wbits;
      if (fsel_en)  fsel_o  <= wbits;
      if (swev_en)  swev_o  <= wbits;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_IMASK: rdata = DATA_W'(imask_o);
      SEL_EMASK: rdata = DATA_W'(emask_o);
      SEL_RSEL:  rdata = DATA_W'(rsel_o);
      SEL_FSEL:  rdata = DATA_W'(fsel_o);
      SEL_SWEV:  rdata = DATA_W'(swev_o);
      SEL_PEND:  rdata = DATA_W'(pend_i);
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/extint_pend.sv
module extint_pend #(
  parameter int unsigned NUM_LINES = 23
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] rise_i,
  input  logic [NUM_LINES-1:0] fall_i,
  input  logic [NUM_LINES-1:0] rsel_i,
  input  logic [NUM_LINES-1:0] fsel_i,
  input  logic [NUM_LINES-1:0] sw_set_i,
  input  logic [NUM_LINES-1:0] clr_i,
  input  logic [NUM_LINES-1:0] imask_i,
  output logic [NUM_LINES-1:0] trig_o,
  output logic [NUM_LINES-1:0] pend_o,
  output logic [NUM_LINES-1:0] pulse_o
);
  logic [NUM_LINES-1:0] pend_d, pulse_d;

  always_comb begin
    trig_o  = (rise_i & rsel_i) | (fall_i & fsel_i) | sw_set_i;
    pend_d  = (pend_o & ~clr_i) | trig_o;
    pulse_d = trig_o & imask_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o  <= '0;
      pulse_o <= '0;
    end else begin
      pend_o  <= pend_d;
      pulse_o <= pulse_d;
    end
  end
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl #(
  parameter int unsigned NUM_LINES   = 23,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_in,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic [NUM_LINES-1:0] irq_pulse
);
  logic [NUM_LINES-1:0] rise, fall, imask, emask, rsel, fsel, swev;
  logic [NUM_LINES-1:0] sw_set, clr, trig, pend;

  extint_sync #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_i(line_in), .rise_o(rise), .fall_o(fall)
  );

  extint_regs #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .pend_i(pend), .rdata(rdata), .imask_o(imask), .emask_o(emask),
    .rsel_o(rsel), .fsel_o(fsel), .swev_o(swev), .sw_set_o(sw_set), .clr_o(clr)
  );

  extint_pend #(.NUM_LINES(NUM_LINES)) u_pend (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .fall_i(fall), .rsel_i(rsel),
    .fsel_i(fsel), .sw_set_i(sw_set), .clr_i(clr), .imask_i(imask),
    .trig_o(trig), .pend_o(pend), .pulse_o(irq_pulse)
  );
endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk
  import extint_pkg::*;
#(
  parameter int unsigned NUM_LINES = 23,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    wdata,
  input logic [DATA_W-1:0]    rdata,
  input logic [NUM_LINES-1:0] irq_pulse,
  input logic [NUM_LINES-1:0] imask,
  input logic [NUM_LINES-1:0] pend,
  input logic [NUM_LINES-1:0] trig
);
  logic pend_wr, swev_wr, mapped;

  always_comb begin
    pend_wr = wr_en && (addr == ADDR_W'(OFS_PEND));
    swev_wr = wr_en && (addr == ADDR_W'(OFS_SWEV));
    mapped  = (addr == ADDR_W'(OFS_IMASK)) || (addr == ADDR_W'(OFS_EMASK)) ||
              (addr == ADDR_W'(OFS_RSEL))  || (addr == ADDR_W'(OFS_FSEL))  ||
              (addr == ADDR_W'(OFS_SWEV))  || (addr == ADDR_W'(OFS_PEND));
  end

  if (NUM_LINES < DATA_W) begin : g_upper
    AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[DATA_W-1:NUM_LINES] == '0); // R2
  end

  AST_EVENT_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (trig != '0) |=> ((pend & $past(trig)) == $past(trig))); // R7

  AST_CLEAR_ONLY_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    pend_wr |=> ((pend & $past(wdata[NUM_LINES-1:0]) & ~$past(trig)) == '0)); // R6

  AST_NO_PULSE_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_pulse & ~$past(imask)) == '0)); // R8

  AST_SW_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    swev_wr |=> ((pend & $past(wdata[NUM_LINES-1:0])) == $past(wdata[NUM_LINES-1:0]))); // R9

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (rdata == '0)); // R10
endmodule

bind extint_ctrl extint_ctrl_chk #(
  .NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .irq_pulse(irq_pulse), .imask(imask), .pend(pend), .trig(trig)
);

// File: tb/extint_ctrl_tb_top.sv
module extint_ctrl_tb_top;
  localparam int unsigned NL = 23;
  localparam logic [31:0] LMASK = (32'h1 << NL) - 1;
  localparam logic [7:0] A_IM = 8'h00, A_EM = 8'h04, A_RS = 8'h08,
                         A_FS = 8'h0C, A_SW = 8'h10, A_PD = 8'h14;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NL-1:0] line_in;
  logic          wr_en;
  logic [7:0]    addr;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic [NL-1:0] irq_pulse;

  int unsigned n_chk = 0, n_bad = 0;
  logic [31:0] m_im, m_rs, m_fs, m_pd;

  always #2 clk = ~clk;

  extint_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_pulse(irq_pulse)
  );

  function automatic logic [31:0] exp_trig(logic [31:0] o, logic [31:0] n,
                                           logic [31:0] rs, logic [31:0] fs);
    return ((n & ~o & rs) | (~n & o & fs)) & LMASK;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  // drive a new line vector and check pending and pulse three edges later
  task automatic edge_step(string req, logic [NL-1:0] nv);
    logic [31:0] t;
    @(negedge clk);
    t = exp_trig(32'(line_in), 32'(nv), m_rs, m_fs);
    line_in = nv;
    @(negedge clk);
    @(negedge clk);
    check({req, " no early pulse"}, 32'(irq_pulse), 32'h0);
    @(negedge clk);
    check({req, " pulse"}, 32'(irq_pulse), t & m_im);
    m_pd = m_pd | t;
    rd_chk({req, " pending"}, A_PD, m_pd);
    @(negedge clk);
    check({req, " pulse one cycle"}, 32'(irq_pulse), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5eed_0017));
    rst_n = 1'b0; line_in = '0; wr_en = 1'b0; addr = '0; wdata = '0;
    m_im = 0; m_rs = 0; m_fs = 0; m_pd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk("R1 imask", A_IM, 0); rd_chk("R1 emask", A_EM, 0);
    rd_chk("R1 rsel", A_RS, 0);  rd_chk("R1 fsel", A_FS, 0);
    rd_chk("R1 swev", A_SW, 0);  rd_chk("R1 pend", A_PD, 0);
    check("R1 pulse", 32'(irq_pulse), 0);

    // R2 readback, upper bits zero
    wr(A_IM, 32'hFFFF_FFFF); rd_chk("R2 imask", A_IM, LMASK);
    wr(A_EM, 32'hA5A5_A5A5); rd_chk("R2 emask", A_EM, 32'hA5A5_A5A5 & LMASK);
    wr(A_RS, 32'h1234_5678); rd_chk("R2 rsel", A_RS, 32'h1234_5678 & LMASK);
    wr(A_FS, 32'hFF80_0001); rd_chk("R2 fsel", A_FS, 32'h0000_0001);
    wr(A_IM, 0); wr(A_EM, 0); wr(A_RS, 0); wr(A_FS, 0);

    // R10 unmapped offsets
    wr(8'h18, 32'hFFFF_FFFF);
    check("R10 no pulse on unmapped write", 32'(irq_pulse), 0);
    wr(8'hFC, 32'hFFFF_FFFF); wr(8'h01, 32'hFFFF_FFFF);
    rd_chk("R10 read 0x18", 8'h18, 0); rd_chk("R10 read 0xFC", 8'hFC, 0);
    rd_chk("R10 imask intact", A_IM, 0); rd_chk("R10 pend intact", A_PD, 0);
    rd_chk("R10 swev intact", A_SW, 0);

    // R9 software event
    wr(A_IM, 32'h5); m_im = 32'h5;
    wr(A_SW, 32'h7);
    check("R9 sw pulse", 32'(irq_pulse), 32'h5);
    rd_chk("R9 sw pend", A_PD, 32'h7);
    rd_chk("R9 sw readback", A_SW, 32'h7);
    @(negedge clk);
    check("R9 sw pulse one cycle", 32'(irq_pulse), 0);

    // R6 write-one-to-clear
    wr(A_PD, 32'h2); rd_chk("R6 clear one bit", A_PD, 32'h5);
    wr(A_PD, 32'h0); rd_chk("R6 zero write keeps", A_PD, 32'h5);
    check("R6 no pulse on clear", 32'(irq_pulse), 0);
    wr(A_PD, 32'hFFFF_FFFF); rd_chk("R6 clear all", A_PD, 0);
    m_pd = 0;

    // R3 R4 R5 directed edges
    wr(A_IM, LMASK); m_im = LMASK;
    wr(A_RS, 32'h1); m_rs = 32'h1;
    wr(A_FS, 32'h2); m_fs = 32'h2;
    edge_step("R3 rise line0 (R5 line1/2)", 23'h7);
    edge_step("R4 fall line1 (R5 line0/2)", 23'h0);
    wr(A_PD, LMASK); m_pd = 0;

    // R8 masked edge: pending set, no pulse
    wr(A_IM, 0); m_im = 0;
    edge_step("R8 masked rise", 23'h1);
    wr(A_PD, LMASK); m_pd = 0;

    // R7 set wins over clear in the same cycle
    wr(A_SW, 32'h8); m_pd = 32'h8;
    @(negedge clk);
    line_in = 23'h0; m_rs = 32'h0; m_fs = 32'h1;
    wr(A_FS, 32'h1);
    @(negedge clk);
    line_in = 23'h1;
    repeat (3) @(negedge clk);
    // falling edge: the clear write lands on the third edge after the change
    line_in = 23'h0;
    @(negedge clk);
    wr(A_PD, 32'h9);
    rd_chk("R7 set wins over clear", A_PD, 32'h1);
    wr(A_PD, LMASK); m_pd = 0;

    // random mix, R11 via random event mask
    for (int i = 0; i < 300; i++) begin
      m_im = $urandom & LMASK; m_rs = $urandom & LMASK; m_fs = $urandom & LMASK;
      wr(A_IM, m_im); wr(A_RS, m_rs); wr(A_FS, m_fs);
      wr(A_EM, $urandom);
      if (($urandom % 4) == 0) begin
        logic [31:0] s;
        s = $urandom & LMASK;
        wr(A_SW, s);
        check("R9 random sw pulse", 32'(irq_pulse), s & m_im);
        m_pd = m_pd | s;
      end
      edge_step("R11 R3 R4 random edges", NL'($urandom));
      if (($urandom % 2) == 0) begin
        logic [31:0] c;
        c = $urandom;
        wr(A_PD, c);
        m_pd = m_pd & ~c;
        rd_chk("R6 random clear", A_PD, m_pd);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule